// File: doc/BRIEF.md
# Nibble-Bus Single-Byte Read Initiator

This block sits on the host side of a 4-bit multiplexed nibble bus and performs one single-byte memory read for each accepted request. A request carries a 4-bit target identifier and a 28-bit byte address. The block frames the cycle, sends the header nibbles, and hands the bus to the target. It then waits for the target to report ready, collects the data byte, lets the target hand the bus back, and returns the byte with a one-clock done pulse.

The target may insert any number of wait nibbles before it reports ready. A timer bounds that wait so that a silent target cannot hang the host. Data arrives low nibble first and the block rebuilds the byte from the two nibbles. The bus is modelled as separate drive (`bus_out`), drive-enable (`bus_oe`) and sense (`bus_in`) signals, so the pad or tri-state buffer lives outside this block.

The controller is a single state machine with these states: `ST_IDLE`, `ST_START`, `ST_DEVID`, `ST_ADDR`, `ST_SIZE`, `ST_HTAR0`, `ST_HTAR1`, `ST_SYNC`, `ST_DLO`, `ST_DHI`, `ST_TTAR0`, `ST_TTAR1`, `ST_DONE` and `ST_ERR`. Its transitions are:
- IDLE to START when a request is accepted.
- START to DEVID, and DEVID to ADDR.
- ADDR stays in ADDR until the last address nibble has gone out, then moves to SIZE.
- SIZE to HTAR0, HTAR0 to HTAR1, and HTAR1 to SYNC.
- SYNC to DLO when the ready nibble is seen, to ERR when the timer expires, and otherwise stays in SYNC.
- DLO to DHI, DHI to TTAR0, TTAR0 to TTAR1, and TTAR1 to DONE.
- DONE to IDLE, and ERR to IDLE.

Top module: `nbus_rd_init`

## Requirements
- R1: In the clock after a request is accepted, `frame_n` is low and the block drives 1101 with `bus_oe`=1. `frame_n` is low for exactly that one clock and stays high for the rest of the cycle.
- R2: The clocks that follow carry, one nibble per clock with `bus_oe`=1: the target ID, then the seven address nibbles (most-significant first, so address bits 27:24 go first), then the size nibble 0000.
- R3: After the size nibble, the block drives 1111 for one clock. It then releases the bus (`bus_oe`=0) on the next clock.
- R4: From the clock after the release, every sensed nibble other than 0000 is a wait; the normal wait code is 0101, and any other non-0000 value is treated the same way. The block accepts any number of waits from 0 to TMO_CYC-1 (31 by default).
- R5: Sensing 0000 (ready) means the next sensed nibble is data bits 3:0 and the one after it is data bits 7:4. `rd_data` equals {high, low}.
- R6: After the high data nibble, the bus stays released for two target turnaround clocks. On the third clock `rd_done` is 1 for exactly one clock with `rd_data` valid, and the block drives 1111 with `bus_oe`=1 again.
- R7: If TMO_CYC consecutive non-0000 nibbles are sensed in the sync phase, the next clock shows `rd_err`=1 for one clock and `rd_done` stays 0. The block then returns to idle.
- R8: `req_ready` is 1 only when idle. A request presented while it is 0 is ignored: the nibbles of the cycle in progress are unchanged and no new frame starts.
- R9: After reset: `frame_n`=1, `bus_oe`=1, `bus_out`=1111, `req_ready`=1, `rd_done`=0 and `rd_err`=0.
- R10: In idle, the block owns the bus and drives 1111 with `frame_n` high. It resumes this in the clock after the second target turnaround clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_id | input | 4 | Target identifier |
| req_addr | input | ADDR_W (28) | Byte address |
| req_ready | output | 1 | Block idle, request will be taken |
| rd_data | output | 8 | Returned byte |
| rd_done | output | 1 | One-clock completion pulse |
| rd_err | output | 1 | One-clock timeout pulse |
| frame_n | output | 1 | Active-low frame strobe |
| bus_out | output | 4 | Nibble driven onto the bus |
| bus_oe | output | 1 | Drive enable for bus_out |
| bus_in | input | 4 | Nibble sensed from the bus |

## Verification
The bench aims at the edges of the wait count.

- With zero waits, the ready nibble comes in the first sync clock. A design that samples sync one clock late would take the low data nibble for the ready code and misplace the byte.
- With TMO_CYC-1 waits, the read must still succeed. With TMO_CYC waits it must flag an error. An off-by-one timer would either abort a legal read or accept an expired one.
- Non-0101 wait nibbles check that only 0000 ends the wait.
- Requests held high during a busy cycle, with a different ID and address, would corrupt the address nibbles or start a second frame if the idle gating were wrong.
- Random bytes catch a swapped nibble order.

// File: rtl/nbus_rd_pkg.sv
package nbus_rd_pkg;

    localparam int NIB_W = 4;

    localparam logic [NIB_W-1:0] NIB_START = 4'b1101;
    localparam logic [NIB_W-1:0] NIB_SIZE1 = 4'b0000;
    localparam logic [NIB_W-1:0] NIB_HIGH  = 4'b1111;
    localparam logic [NIB_W-1:0] NIB_READY = 4'b0000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_DEVID,
        ST_ADDR,
        ST_SIZE,
        ST_HTAR0,
        ST_HTAR1,
        ST_SYNC,
        ST_DLO,
        ST_DHI,
        ST_TTAR0,
        ST_TTAR1,
        ST_DONE,
        ST_ERR
    } rd_state_e;

endpackage

// File: rtl/nbus_rd_seq.sv
module nbus_rd_seq
    import nbus_rd_pkg::*;
#(
    parameter int ADDR_NIBS = 7,
    parameter int IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_fire,
    input  logic             sync_ready,
    input  logic             tmo_hit,
    output rd_state_e        state,
    output logic [IDX_W-1:0] nib_idx
);

    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(ADDR_NIBS - 1);

    rd_state_e state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // address nibble index, counts down while in ST_ADDR
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nib_idx <= IDX_TOP;
        end else if (state == ST_DEVID) begin
            nib_idx <= IDX_TOP;
        end else if (state == ST_ADDR && nib_idx != '0) begin
            nib_idx <= nib_idx - 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_fire) state_nx = ST_START;
            ST_START: state_nx = ST_DEVID;
            ST_DEVID: state_nx = ST_ADDR;
            ST_ADDR:  if (nib_idx == '0) state_nx = ST_SIZE;
            ST_SIZE:  state_nx = ST_HTAR0;
            ST_HTAR0: state_nx = ST_HTAR1;
            ST_HTAR1: state_nx = ST_SYNC;
            ST_SYNC: begin
                if (sync_ready)   state_nx = ST_DLO;
                else if (tmo_hit) state_nx = ST_ERR;
            end
            ST_DLO:   state_nx = ST_DHI;
            ST_DHI:   state_nx = ST_TTAR0;
            ST_TTAR0: state_nx = ST_TTAR1;
            ST_TTAR1: state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            ST_ERR:   state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/nbus_rd_reqlat.sv
module nbus_rd_reqlat #(
    parameter int ADDR_W = 28,
    parameter int ID_W   = 4,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ID_W-1:0]   id_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [IDX_W-1:0]  nib_idx,
    output logic [ID_W-1:0]   id_q,
    output logic [3:0]        addr_nib
);

    localparam int ADDR_NIBS = ADDR_W / 4;

    logic [ADDR_W-1:0] addr_q;
    logic [3:0]        nib_arr [ADDR_NIBS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q   <= '0;
            addr_q <= '0;
        end else if (load) begin
            id_q   <= id_in;
            addr_q <= addr_in;
        end
    end

    // split the held address into nibbles; entry k holds bits 4k+3:4k
    for (genvar k = 0; k < ADDR_NIBS; k++) begin : g_nib
        assign nib_arr[k] = addr_q[4*k +: 4];
    end

    always_comb begin
        addr_nib = 4'h0;
        for (int k = 0; k < ADDR_NIBS; k++) begin
            if (nib_idx == IDX_W'(k)) addr_nib = nib_arr[k];
        end
    end

endmodule

// File: rtl/nbus_rd_tmo.sv
module nbus_rd_tmo #(
    parameter int TMO_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_sync,
    input  logic sync_ready,
    output logic tmo_hit
);

    localparam int TMO_W = $clog2(TMO_CYC + 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYC - 1);

    logic [TMO_W-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (!in_sync || sync_ready) begin
            wait_cnt <= '0;
        end else if (wait_cnt != TMO_LAST) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    assign tmo_hit = in_sync && !sync_ready && (wait_cnt == TMO_LAST);

endmodule

// File: rtl/nbus_rd_byteasm.sv
module nbus_rd_byteasm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_lo,
    input  logic       cap_hi,
    input  logic [3:0] nib_in,
    output logic [7:0] byte_q
);

    logic [3:0] lo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            byte_q <= '0;
        end else begin
            if (cap_lo) lo_q   <= nib_in;
            if (cap_hi) byte_q <= {nib_in, lo_q};
        end
    end

endmodule

// File: rtl/nbus_rd_init.sv
module nbus_rd_init
    import nbus_rd_pkg::*;
#(
    parameter int ADDR_W  = 28,
    parameter int ID_W    = 4,
    parameter int TMO_CYC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ID_W-1:0]   req_id,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic [7:0]        rd_data,
    output logic              rd_done,
    output logic              rd_err,
    output logic              frame_n,
    output logic [3:0]        bus_out,
    output logic              bus_oe,
    input  logic [3:0]        bus_in
);

    localparam int ADDR_NIBS = ADDR_W / 4;
    localparam int IDX_W     = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;

    rd_state_e        state;
    logic [IDX_W-1:0] nib_idx;
    logic [ID_W-1:0]  id_q;
    logic [3:0]       addr_nib;
    logic             req_fire;
    logic             sync_ready;
    logic             tmo_hit;

    assign req_fire   = req_valid && (state == ST_IDLE);
    assign sync_ready = (state == ST_SYNC) && (bus_in == NIB_READY);

    nbus_rd_seq #(
        .ADDR_NIBS (ADDR_NIBS),
        .IDX_W     (IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_fire   (req_fire),
        .sync_ready (sync_ready),
        .tmo_hit    (tmo_hit),
        .state      (state),
        .nib_idx    (nib_idx)
    );

    nbus_rd_reqlat #(
        .ADDR_W (ADDR_W),
        .ID_W   (ID_W),
        .IDX_W  (IDX_W)
    ) u_reqlat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (req_fire),
        .id_in    (req_id),
        .addr_in  (req_addr),
        .nib_idx  (nib_idx),
        .id_q     (id_q),
        .addr_nib (addr_nib)
    );

    nbus_rd_tmo #(
        .TMO_CYC (TMO_CYC)
    ) u_tmo (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_sync    (state == ST_SYNC),
        .sync_ready (sync_ready),
        .tmo_hit    (tmo_hit)
    );

    nbus_rd_byteasm u_asm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_lo (state == ST_DLO),
        .cap_hi (state == ST_DHI),
        .nib_in (bus_in),
        .byte_q (rd_data)
    );

    // output decode
    always_comb begin
        frame_n   = 1'b1;
        bus_out   = NIB_HIGH;
        bus_oe    = 1'b0;
        req_ready = 1'b0;
        rd_done   = 1'b0;
        rd_err    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                bus_oe    = 1'b1;
                req_ready = 1'b1;
            end
            ST_START: begin
                frame_n = 1'b0;
                bus_out = NIB_START;
                bus_oe  = 1'b1;
            end
            ST_DEVID: begin
                bus_out = 4'(id_q);
                bus_oe  = 1'b1;
            end
            ST_ADDR: begin
                bus_out = addr_nib;
                bus_oe  = 1'b1;
            end
            ST_SIZE: begin
                bus_out = NIB_SIZE1;
                bus_oe  = 1'b1;
            end
            ST_HTAR0: begin
                bus_out = NIB_HIGH;
                bus_oe  = 1'b1;
            end
            ST_HTAR1, ST_SYNC, ST_DLO, ST_DHI, ST_TTAR0, ST_TTAR1: begin
                bus_oe = 1'b0;
            end
            ST_DONE: begin
                bus_oe  = 1'b1;
                rd_done = 1'b1;
            end
            ST_ERR: begin
                rd_err = 1'b1;
            end
            default: begin
                bus_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/nbus_rd_chk.sv
module nbus_rd_chk
    import nbus_rd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       rd_done,
    input logic       rd_err,
    input logic       frame_n,
    input logic [3:0] bus_out,
    input logic       bus_oe,
    input logic [3:0] bus_in
);

    AST_START_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n) |-> (bus_out == NIB_START) && bus_oe); // R1

    AST_FRAME_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> frame_n); // R1

    AST_NO_FRAME_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> frame_n); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done); // R6

    AST_DONE_AFTER_TTAR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> !$past(bus_oe, 1) && !$past(bus_oe, 2)); // R6

    AST_ERR_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_err && rd_done)); // R7

    AST_ERR_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> ($past(bus_in) != NIB_READY) && !$past(bus_oe)); // R7

endmodule

bind nbus_rd_init nbus_rd_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rd_done   (rd_done),
    .rd_err    (rd_err),
    .frame_n   (frame_n),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .bus_in    (bus_in)
);

// File: tb/nbus_rd_init_tb.sv
`timescale 1ns/1ps
module nbus_rd_init_tb;

    localparam int TMO = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_id = '0;
    logic [27:0] req_addr = '0;
    logic        req_ready;
    logic [7:0]  rd_data;
    logic        rd_done;
    logic        rd_err;
    logic        frame_n;
    logic [3:0]  bus_out;
    logic        bus_oe;
    logic [3:0]  bus_in = 4'hF;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    nbus_rd_init u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_id    (req_id),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .rd_data   (rd_data),
        .rd_done   (rd_done),
        .rd_err    (rd_err),
        .frame_n   (frame_n),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .bus_in    (bus_in)
    );

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [3:0] addr_nib(input logic [27:0] a, input int k);
        return 4'((a >> (4 * (6 - k))) & 28'hF);
    endfunction

    // host nibble phase check: expects frame_n, drive enable, nibble
    task automatic chk_host(input logic fr, input logic [3:0] nib, input string tag);
        chk({31'd0, frame_n}, {31'd0, fr}, tag);
        chk({31'd0, bus_oe}, 32'd1, tag);
        chk({28'd0, bus_out}, {28'd0, nib}, tag);
    endtask

    task automatic run_read(input logic [3:0] id, input logic [27:0] addr, input int waits,
                            input logic [7:0] dat, input bit tmo, input bit alt, input bit poke);
        @(negedge clk);
        chk({31'd0, req_ready}, 32'd1, "R8 ready before request");
        req_valid = 1'b1;
        req_id    = id;
        req_addr  = addr;
        @(negedge clk);
        if (poke) begin
            req_id   = ~id;
            req_addr = ~addr;
        end else begin
            req_valid = 1'b0;
        end
        chk_host(1'b0, 4'b1101, "R1 start nibble");
        chk({31'd0, req_ready}, 32'd0, "R8 busy");
        @(negedge clk);
        chk_host(1'b1, id, "R2 id nibble");
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            chk_host(1'b1, addr_nib(addr, k), "R2 address nibble");
        end
        @(negedge clk);
        chk_host(1'b1, 4'b0000, "R2 size nibble");
        @(negedge clk);
        chk_host(1'b1, 4'b1111, "R3 host turnaround drive");
        @(negedge clk);
        chk({31'd0, bus_oe}, 32'd0, "R3 release");
        chk({31'd0, frame_n}, 32'd1, "R1 frame high");
        for (int w = 0; w < waits; w++) begin
            @(negedge clk);
            bus_in = (alt && w[0]) ? 4'b0110 : 4'b0101;
            chk({31'd0, bus_oe}, 32'd0, "R4 released during wait");
            chk({31'd0, rd_err | rd_done}, 32'd0, "R4 still waiting");
        end
        if (tmo) begin
            @(negedge clk);
            req_valid = 1'b0;
            chk({31'd0, rd_err}, 32'd1, "R7 timeout error");
            chk({31'd0, rd_done}, 32'd0, "R7 no done");
            bus_in = 4'hF;
            @(negedge clk);
            chk({31'd0, req_ready}, 32'd1, "R7 back to idle");
            chk({31'd0, rd_err}, 32'd0, "R7 error one clock");
            return;
        end
        @(negedge clk);
        bus_in = 4'b0000;
        @(negedge clk);
        bus_in = dat[3:0];
        @(negedge clk);
        bus_in = dat[7:4];
        @(negedge clk);
        bus_in = 4'b1111;
        chk({31'd0, bus_oe}, 32'd0, "R6 target turnaround 0");
        chk({31'd0, rd_done}, 32'd0, "R6 no early done");
        @(negedge clk);
        chk({31'd0, bus_oe}, 32'd0, "R6 target turnaround 1");
        @(negedge clk);
        req_valid = 1'b0;
        chk({31'd0, rd_done}, 32'd1, "R6 done pulse");
        chk({24'd0, rd_data}, {24'd0, dat}, "R5 data byte");
        chk_host(1'b1, 4'b1111, "R10 host resumes bus");
        chk({31'd0, rd_err}, 32'd0, "R7 no error on success");
        @(negedge clk);
        chk({31'd0, rd_done}, 32'd0, "R6 done one clock");
        chk({31'd0, req_ready}, 32'd1, "R8 ready again");
        chk_host(1'b1, 4'b1111, "R10 idle bus");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5A5A));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk({31'd0, frame_n}, 32'd1, "R9 frame_n");
        chk({31'd0, bus_oe}, 32'd1, "R9 bus_oe");
        chk({28'd0, bus_out}, 32'hF, "R9 bus_out");
        chk({31'd0, req_ready}, 32'd1, "R9 req_ready");
        chk({30'd0, rd_done, rd_err}, 32'd0, "R9 no pulses");

        run_read(4'h3, 28'h89A_BCDE, 0, 8'hA5, 1'b0, 1'b0, 1'b0);      // R4 zero waits
        run_read(4'hC, 28'h012_3456, 2, 8'h3C, 1'b0, 1'b0, 1'b0);
        run_read(4'h0, 28'hFFF_FFFF, TMO - 1, 8'h7E, 1'b0, 1'b0, 1'b0); // R4 max waits
        run_read(4'h9, 28'h555_AAAA, TMO, 8'h00, 1'b1, 1'b0, 1'b0);     // R7 timeout
        run_read(4'h6, 28'hABC_0123, 5, 8'hF0, 1'b0, 1'b1, 1'b0);       // R4 other wait codes
        run_read(4'h5, 28'h0F0_F0F0, 3, 8'h96, 1'b0, 1'b0, 1'b1);       // R8 poke while busy
        run_read(4'hA, 28'h123_4567, TMO, 8'h11, 1'b1, 1'b1, 1'b1);     // R7, R8

        for (int n = 0; n < 40; n++) begin
            run_read(4'($urandom), 28'($urandom), int'($urandom % TMO), 8'($urandom),
                     1'b0, 1'($urandom), 1'($urandom));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule